// File: doc/BRIEF.md
# SPI-mode SD command sequencer

This block is the byte-level front end of a bridge between an SPI host and an SD card model. The host side moves one byte at a time. Each accepted exchange takes one byte from the host and, one clock later, hands back one byte for the host. The sequencer gathers a command byte and its four argument bytes, plus one trailing check byte that it ignores. It then sends the command over a valid/ready request port to the card side and stalls further exchanges until the card side returns a response. The response comes back with a length and up to five bytes.

Once the response arrives, the host first receives one filler byte, then the response bytes in order, then one trailing filler byte. After that the sequencer either returns to idle or, when the card side reports pending read data, passes the byte stream to a separate read engine. Commands that signal busy completion (indices 28, 29 and 38) never pass to the read engine. A stop command byte (0x4C) sent while read data is flowing aborts the read. It starts collecting a stop command and marks the exchange as stopping. The data tokens 0xFC and 0xFE pass the stream to a separate write engine. With no card present, every exchange returns 0xFF and nothing moves.

States: IDLE (waits for a command byte), ARG (collects the argument and check bytes), ISSUE (holds the request until accepted), WAIT (waits for the response), GAP (sends the filler byte), RESP (sends the response bytes and then the trailing byte), READ (read engine handoff), WRITE (write engine handoff). Transitions: IDLE→ARG on a command byte; IDLE→WRITE on 0xFC/0xFE; ARG→ISSUE on the check byte; ISSUE→WAIT on cmd_ready; WAIT→GAP on rsp_valid; GAP→RESP on the next exchange; RESP→IDLE or RESP→READ on the trailing byte; READ→IDLE on the last read byte; READ→ARG on 0x4C; WRITE→IDLE on the last write byte.

Top module: `sdspi_cmd_seq`

## Requirements
- R1: While card_present is low, every accepted exchange returns 0xFF and leaves the sequencer state, argument and response progress unchanged.
- R2: In IDLE, the null byte 0xFF and the stop token 0xFD each return 0xFF and leave the sequencer in IDLE.
- R3: In IDLE, any byte other than 0xFF, 0xFC, 0xFD or 0xFE is a command byte, and its low 6 bits become cmd_index. The next four bytes form cmd_arg, most significant byte first. The fifth byte after the command byte is ignored, and on it the request is raised.
- R4: cmd_valid stays high with stable cmd_index and cmd_arg until cmd_ready is seen. xfer_ready is low from the request until rsp_valid returns.
- R5: The first exchange after the response is received returns 0xFF (the response gap).
- R6: The response bytes follow, one per exchange. Byte k is rsp_data[8k+7:8k], starting at k=0, and the count is min(rsp_len, 5). One trailing exchange then returns 0xFF.
- R7: For command indices 28, 29 and 38, the trailing exchange returns the sequencer to IDLE even when data_ready is high.
- R8: For other commands, the trailing exchange enters READ if data_ready is high and IDLE otherwise. In READ, each exchange returns rd_byte and pulses rd_strobe. The exchange made with rd_last high returns to IDLE.
- R9: In READ, the byte 0x4C returns 0xFF and starts collection of command 12 with the stopping flag set. That command's trailing exchange then returns to IDLE whatever data_ready is.
- R10: In IDLE, the tokens 0xFC and 0xFE enter WRITE. There, each exchange returns 0xFF and pulses wr_strobe with wr_byte equal to the host byte. The exchange made with rd_last's write twin, wr_last, high returns to IDLE.
- R11: After reset: xfer_ready is 1, cmd_valid is 0, xfer_done is 0, xfer_miso is 0xFF, and the state is IDLE.
- R12: Each exchange accepted on a rising edge (xfer_valid and xfer_ready) raises xfer_done for exactly the following cycle. All bytes returned during command and argument collection are 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| card_present | input | 1 | High when a card is attached |
| xfer_valid | input | 1 | Host offers one byte exchange |
| xfer_ready | output | 1 | Sequencer can accept an exchange |
| xfer_mosi | input | 8 | Byte from the host |
| xfer_done | output | 1 | Result byte valid (one cycle after acceptance) |
| xfer_miso | output | 8 | Byte returned to the host |
| cmd_valid | output | 1 | Command request to the card side |
| cmd_ready | input | 1 | Card side accepts the request |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Card side response is present |
| rsp_len | input | 3 | Response length in bytes (clamped to 5) |
| rsp_data | input | 40 | Response bytes, byte 0 in bits 7:0 |
| data_ready | input | 1 | Card side has read data pending |
| rd_strobe | output | 1 | Read engine byte taken this exchange |
| rd_byte | input | 8 | Byte offered by the read engine |
| rd_last | input | 1 | Current read byte is the last |
| wr_strobe | output | 1 | Write engine byte delivered this exchange |
| wr_byte | output | 8 | Byte for the write engine |
| wr_last | input | 1 | Current write byte is the last |

## Verification
The assertions assume that the card side raises cmd_ready only while a request is pending and raises rsp_valid only after accepting one. They also assume that xfer_mosi, card_present, rd_byte, rd_last and wr_last are stable whenever xfer_valid is sampled. The bench's card model answers a request only after it sees cmd_valid. It pulses cmd_ready, and then rsp_valid, for one cycle each. The host driver changes every input only on the falling clock edge and waits for xfer_ready before offering a byte, so no exchange is ever offered while a command is pending.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARG,
        ST_ISSUE,
        ST_WAIT,
        ST_GAP,
        ST_RESP,
        ST_READ,
        ST_WRITE
    } seq_state_t;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [7:0] TOK_MULTI   = 8'hFC;
    localparam logic [7:0] TOK_HALT    = 8'hFD;
    localparam logic [7:0] TOK_SINGLE  = 8'hFE;
    localparam logic [7:0] ABORT_BYTE  = 8'h4C;

    function automatic logic is_busy_cmd(input logic [5:0] idx);
        return (idx == 6'd28) || (idx == 6'd29) || (idx == 6'd38);
    endfunction

endpackage

// File: rtl/sdspi_byte_class.sv
module sdspi_byte_class
    import sdspi_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] din,
    output logic              is_null,
    output logic              is_halt,
    output logic              is_data_tok,
    output logic              is_abort
);
    always_comb begin
        is_null     = (din == FILL_BYTE);
        is_halt     = (din == TOK_HALT);
        is_data_tok = (din == TOK_MULTI) || (din == TOK_SINGLE);
        is_abort    = (din == ABORT_BYTE);
    end
endmodule

// File: rtl/sdspi_arg_shift.sv
module sdspi_arg_shift #(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      shift,
    input  logic [BYTE_W-1:0]         din,
    output logic [N_BYTES*BYTE_W-1:0] arg_q,
    output logic                      full
);
    localparam int ARG_W = N_BYTES * BYTE_W;
    localparam int CNT_W = $clog2(N_BYTES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            arg_q <= '0;
            cnt_q <= '0;
        end else if (shift && !full) begin
            arg_q <= {arg_q[ARG_W-BYTE_W-1:0], din};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign full = (cnt_q == CNT_W'(N_BYTES));
endmodule

// File: rtl/sdspi_rsp_buf.sv
module sdspi_rsp_buf #(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 5,
    parameter int LEN_W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [LEN_W-1:0]            len_in,
    input  logic [MAX_BYTES*BYTE_W-1:0] data_in,
    input  logic                        adv,
    output logic [BYTE_W-1:0]           cur,
    output logic                        more
);
    logic [BYTE_W-1:0] slot_q [MAX_BYTES];
    logic [LEN_W-1:0]  left_q;
    logic [LEN_W-1:0]  len_clamped;

    assign len_clamped = (len_in > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : len_in;

    for (genvar k = 0; k < MAX_BYTES; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[k] <= '0;
            end else if (load) begin
                slot_q[k] <= data_in[k*BYTE_W +: BYTE_W];
            end else if (adv) begin
                if (k == MAX_BYTES - 1) slot_q[k] <= '0;
                else                    slot_q[k] <= slot_q[(k+1) % MAX_BYTES];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               left_q <= '0;
        else if (load)            left_q <= len_clamped;
        else if (adv && more)     left_q <= left_q - 1'b1;
    end

    assign cur  = slot_q[0];
    assign more = (left_q != '0);
endmodule

// File: rtl/sdspi_cmd_seq.sv
module sdspi_cmd_seq
    import sdspi_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int ARG_BYTES = 4,
    parameter int RSP_MAX   = 5,
    parameter int IDX_W     = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      card_present,
    input  logic                      xfer_valid,
    output logic                      xfer_ready,
    input  logic [BYTE_W-1:0]         xfer_mosi,
    output logic                      xfer_done,
    output logic [BYTE_W-1:0]         xfer_miso,
    output logic                      cmd_valid,
    input  logic                      cmd_ready,
    output logic [IDX_W-1:0]          cmd_index,
    output logic [ARG_BYTES*BYTE_W-1:0] cmd_arg,
    input  logic                      rsp_valid,
    input  logic [$clog2(RSP_MAX+1)-1:0] rsp_len,
    input  logic [RSP_MAX*BYTE_W-1:0] rsp_data,
    input  logic                      data_ready,
    output logic                      rd_strobe,
    input  logic [BYTE_W-1:0]         rd_byte,
    input  logic                      rd_last,
    output logic                      wr_strobe,
    output logic [BYTE_W-1:0]         wr_byte,
    input  logic                      wr_last
);
    localparam int LEN_W = $clog2(RSP_MAX + 1);

    seq_state_t state, state_d;

    logic              fire, active;
    logic              cls_null, cls_halt, cls_data, cls_abort;
    logic              arg_clr, arg_shift, arg_full;
    logic              idx_load, stop_set, stop_clr, stop_q;
    logic              rsp_load, rsp_adv, rsp_more;
    logic [BYTE_W-1:0] rsp_cur, miso_d;
    logic [IDX_W-1:0]  idx_q;
    logic              rd_take, wr_take;

    assign xfer_ready = (state != ST_ISSUE) && (state != ST_WAIT);
    assign fire       = xfer_valid && xfer_ready;
    assign active     = fire && card_present;
    assign rsp_load   = (state == ST_WAIT) && rsp_valid;

    sdspi_byte_class #(.BYTE_W(BYTE_W)) u_class (
        .din         (xfer_mosi),
        .is_null     (cls_null),
        .is_halt     (cls_halt),
        .is_data_tok (cls_data),
        .is_abort    (cls_abort)
    );

    sdspi_arg_shift #(.BYTE_W(BYTE_W), .N_BYTES(ARG_BYTES)) u_arg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (arg_clr),
        .shift (arg_shift),
        .din   (xfer_mosi),
        .arg_q (cmd_arg),
        .full  (arg_full)
    );

    sdspi_rsp_buf #(.BYTE_W(BYTE_W), .MAX_BYTES(RSP_MAX), .LEN_W(LEN_W)) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rsp_load),
        .len_in  (rsp_len),
        .data_in (rsp_data),
        .adv     (rsp_adv),
        .cur     (rsp_cur),
        .more    (rsp_more)
    );

    always_comb begin
        state_d   = state;
        miso_d    = FILL_BYTE;
        arg_clr   = 1'b0;
        arg_shift = 1'b0;
        idx_load  = 1'b0;
        stop_set  = 1'b0;
        stop_clr  = 1'b0;
        rsp_adv   = 1'b0;
        rd_take   = 1'b0;
        wr_take   = 1'b0;
        unique case (state)
            ST_IDLE: if (active) begin
                if (cls_data) begin
                    state_d = ST_WRITE;
                end else if (!cls_null && !cls_halt) begin
                    idx_load = 1'b1;
                    arg_clr  = 1'b1;
                    state_d  = ST_ARG;
                end
            end
            ST_ARG: if (active) begin
                if (arg_full) state_d = ST_ISSUE;
                else          arg_shift = 1'b1;
            end
            ST_ISSUE: if (cmd_ready) state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_d = ST_GAP;
            ST_GAP:   if (active)    state_d = ST_RESP;
            ST_RESP: if (active) begin
                if (rsp_more) begin
                    miso_d  = rsp_cur;
                    rsp_adv = 1'b1;
                end else if (stop_q) begin
                    stop_clr = 1'b1;
                    state_d  = ST_IDLE;
                end else if (data_ready) begin
                    state_d = ST_READ;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_READ: if (active) begin
                if (cls_abort) begin
                    idx_load = 1'b1;
                    arg_clr  = 1'b1;
                    stop_set = 1'b1;
                    state_d  = ST_ARG;
                end else begin
                    miso_d  = rd_byte;
                    rd_take = 1'b1;
                    if (rd_last) state_d = ST_IDLE;
                end
            end
            ST_WRITE: if (active) begin
                wr_take = 1'b1;
                if (wr_last) state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // outputs and command context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_done <= 1'b0;
            xfer_miso <= FILL_BYTE;
            idx_q     <= '0;
            stop_q    <= 1'b0;
        end else begin
            xfer_done <= fire;
            if (fire) xfer_miso <= miso_d;
            if (idx_load) idx_q <= xfer_mosi[IDX_W-1:0];
            if (stop_set || (rsp_load && is_busy_cmd(idx_q))) stop_q <= 1'b1;
            else if (stop_clr)                                 stop_q <= 1'b0;
        end
    end

    assign cmd_valid = (state == ST_ISSUE);
    assign cmd_index = idx_q;
    assign rd_strobe = rd_take;
    assign wr_strobe = wr_take;
    assign wr_byte   = xfer_mosi;
endmodule

// File: rtl/sdspi_cmd_seq_chk.sv
module sdspi_cmd_seq_chk
    import sdspi_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        card_present,
    input logic        xfer_valid,
    input logic        xfer_ready,
    input logic [7:0]  xfer_mosi,
    input logic        xfer_done,
    input logic [7:0]  xfer_miso,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [5:0]  cmd_index,
    input logic [31:0] cmd_arg,
    input logic        rd_strobe,
    input logic        wr_strobe,
    input seq_state_t  state
);
    logic fire;
    assign fire = xfer_valid && xfer_ready;

    assert_nocard_inert_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !card_present) |=> (xfer_miso == 8'hFF && $stable(state)));

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_arg) && $stable(cmd_index)));

    assert_stall_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !xfer_ready);

    assert_gap_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && fire && card_present) |=> (xfer_miso == 8'hFF && state == ST_RESP));

    assert_abort_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && fire && card_present && xfer_mosi == 8'h4C)
        |=> (state == ST_ARG && cmd_index == 6'd12 && xfer_miso == 8'hFF));

    assert_done_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> xfer_done);

    assert_done_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !xfer_done);

    assert_handoff_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_strobe, wr_strobe, cmd_valid}));
endmodule

bind sdspi_cmd_seq sdspi_cmd_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .card_present (card_present),
    .xfer_valid   (xfer_valid),
    .xfer_ready   (xfer_ready),
    .xfer_mosi    (xfer_mosi),
    .xfer_done    (xfer_done),
    .xfer_miso    (xfer_miso),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_index    (cmd_index),
    .cmd_arg      (cmd_arg),
    .rd_strobe    (rd_strobe),
    .wr_strobe    (wr_strobe),
    .state        (state)
);

// File: tb/sim_sdspi_cmd_seq.sv
`timescale 1ns/1ps
module sim_sdspi_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_present = 1'b1;
    logic        xfer_valid = 1'b0;
    logic        xfer_ready;
    logic [7:0]  xfer_mosi = 8'hFF;
    logic        xfer_done;
    logic [7:0]  xfer_miso;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_len = 3'd0;
    logic [39:0] rsp_data = '0;
    logic        data_ready = 1'b0;
    logic        rd_strobe;
    logic [7:0]  rd_byte = 8'h77;
    logic        rd_last = 1'b0;
    logic        wr_strobe;
    logic [7:0]  wr_byte;
    logic        wr_last = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    logic [5:0]  exp_idx;
    logic [31:0] exp_arg;
    logic [2:0]  r_len;
    logic [39:0] r_data;

    always #4 clk = ~clk;

    sdspi_cmd_seq u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops one expected byte per completed exchange
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && xfer_done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R12", "unexpected xfer_done", xfer_miso, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string      t = tag_q.pop_front();
                    chk(xfer_miso == e, t, "miso byte", xfer_miso, e);
                end
            end
        end
    end

    // card-side command model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid) begin
                chk(cmd_index == exp_idx, "R3", "cmd_index", cmd_index, exp_idx);
                chk(cmd_arg == exp_arg, "R3", "cmd_arg", cmd_arg, exp_arg);
                chk(!xfer_ready, "R4", "xfer_ready while pending", xfer_ready, 0);
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                repeat (2) @(negedge clk);
                chk(!xfer_ready, "R4", "xfer_ready awaiting response", xfer_ready, 0);
                rsp_len   = r_len;
                rsp_data  = r_data;
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    // driver: one exchange, expected byte queued for the monitor
    task automatic xchg(input logic [7:0] b, input logic [7:0] e, input string tag);
        while (!xfer_ready) @(negedge clk);
        xfer_mosi  = b;
        xfer_valid = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic xchg_wr(input logic [7:0] b, input bit strobe_exp);
        while (!xfer_ready) @(negedge clk);
        xfer_mosi  = b;
        xfer_valid = 1'b1;
        exp_q.push_back(8'hFF);
        tag_q.push_back("R10");
        #1;
        chk(wr_strobe == strobe_exp, "R10", "wr_strobe", wr_strobe, strobe_exp);
        if (strobe_exp) chk(wr_byte == b, "R10", "wr_byte", wr_byte, b);
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] cb, input logic [31:0] arg);
        xchg(cb, 8'hFF, "R12");
        for (int k = 3; k >= 0; k--) xchg(arg[k*8 +: 8], 8'hFF, "R12");
        xchg(8'h95, 8'hFF, "R3");
    endtask

    task automatic get_rsp(input int n);
        xchg(8'hFF, 8'hFF, "R5");
        for (int k = 0; k < n; k++) xchg(8'hFF, r_data[k*8 +: 8], "R6");
        xchg(8'hFF, 8'hFF, "R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(xfer_ready == 1'b1, "R11", "reset xfer_ready", xfer_ready, 1);
        chk(cmd_valid == 1'b0, "R11", "reset cmd_valid", cmd_valid, 0);
        chk(xfer_done == 1'b0, "R11", "reset xfer_done", xfer_done, 0);
        chk(xfer_miso == 8'hFF, "R11", "reset xfer_miso", xfer_miso, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: null byte and halt token in idle
        xchg(8'hFF, 8'hFF, "R2");
        xchg(8'hFD, 8'hFF, "R2");

        // R3/R5/R6: single-byte response, no data pending
        exp_idx = 6'd17; exp_arg = 32'h12345678; r_len = 3'd1; r_data = 40'h00_00_00_00_00;
        send_cmd(8'h51, 32'h12345678);
        get_rsp(1);

        // R6: five-byte response with a length above the cap
        exp_idx = 6'd8; exp_arg = 32'h000001AA; r_len = 3'd7; r_data = 40'hAA_01_00_00_01;
        send_cmd(8'h48, 32'h000001AA);
        get_rsp(5);

        // R1: card removed mid-argument, bytes ignored
        exp_idx = 6'd13; exp_arg = 32'hDEADBEEF; r_len = 3'd2; r_data = 40'h00_00_00_3C_00;
        xchg(8'h4D, 8'hFF, "R12");
        xchg(8'hDE, 8'hFF, "R12");
        xchg(8'hAD, 8'hFF, "R12");
        card_present = 1'b0;
        xchg(8'h11, 8'hFF, "R1");
        xchg(8'h22, 8'hFF, "R1");
        xchg(8'h33, 8'hFF, "R1");
        card_present = 1'b1;
        xchg(8'hBE, 8'hFF, "R12");
        xchg(8'hEF, 8'hFF, "R12");
        xchg(8'h95, 8'hFF, "R3");
        get_rsp(2);

        // R7: busy command returns to idle despite pending data
        data_ready = 1'b1;
        rd_byte = 8'h77;
        exp_idx = 6'd38; exp_arg = 32'h0; r_len = 3'd1; r_data = 40'h0;
        send_cmd(8'h66, 32'h0);
        get_rsp(1);
        xchg(8'hFF, 8'hFF, "R7");

        // R8: read handoff
        exp_idx = 6'd17; exp_arg = 32'h00000200; r_len = 3'd1; r_data = 40'h0;
        send_cmd(8'h51, 32'h00000200);
        get_rsp(1);
        rd_byte = 8'hFE; xchg(8'hFF, 8'hFE, "R8");
        rd_byte = 8'h11; xchg(8'hFF, 8'h11, "R8");
        rd_byte = 8'h22; rd_last = 1'b1; xchg(8'hFF, 8'h22, "R8");
        rd_last = 1'b0; rd_byte = 8'h77;
        xchg(8'hFF, 8'hFF, "R8");

        // R9: stop byte aborts reading
        exp_idx = 6'd18; exp_arg = 32'h0; r_len = 3'd1; r_data = 40'h0;
        send_cmd(8'h52, 32'h0);
        get_rsp(1);
        rd_byte = 8'h5A; xchg(8'hFF, 8'h5A, "R8");
        exp_idx = 6'd12; exp_arg = 32'h0; r_len = 3'd1; r_data = 40'h0;
        xchg(8'h4C, 8'hFF, "R9");
        for (int k = 0; k < 4; k++) xchg(8'h00, 8'hFF, "R9");
        xchg(8'h61, 8'hFF, "R9");
        get_rsp(1);
        rd_byte = 8'h77;
        xchg(8'hFF, 8'hFF, "R9");
        data_ready = 1'b0;

        // R10: write handoff
        xchg_wr(8'hFE, 1'b0);
        xchg_wr(8'hA5, 1'b1);
        wr_last = 1'b1;
        xchg_wr(8'h3C, 1'b1);
        wr_last = 1'b0;
        xchg_wr(8'hFF, 1'b0);

        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, "R12", "outstanding exchanges", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12 watchdog expired actual=hung expected=complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule